// File: doc/BRIEF.md
# Smart-Card Coupler Command Decoder

This block is the digital core of a smart-card coupler. A host writes 8-bit command bytes over an SPI slave port (mode 0, MSB first) that is qualified by an active-low chip select. Several couplers can share one bus, because each one listens only while its own select is low. Each byte carries an address field in bits [7:5]. Depending on that field, the byte is one of four things:

- an operational command, which sets the card reset level, the card clock ratio and the card supply code;
- a configuration write, which sets the detect-switch polarity, the detect reporting mode and the clock edge-rate selection;
- a reset-only write;
- traffic meant for another device, which is ignored.

While a byte is shifted in, the block shifts out an 8-bit status byte on MISO. It also drives the card reset level, the card clock and the supply code, and it enables the card I/O pull-down while the card is unpowered or still powering up.

All logic runs on `clk`. The SPI pins and the detect pin are oversampled and synchronised into that clock. The card clock is a registered output produced inside the block. `clk` is the coupler's double-rate core clock, so the undivided card clock is one core clock high and one core clock low.

Top module: `scc_coupler_top`

## Requirements
- R1: After reset, the outputs are as follows: `supplySel`=00, `cardClk`=0, `cardRst`=0, `ioPullDown`=1, `slopeFast`=0 (slow). The configuration is normally-open polarity with normal reporting.
- R2: While `csN` is high, no SCLK edge or MOSI value changes any output, and `misoOe`=0. If `csN` rises before the eighth bit, the partial byte is discarded. `misoOe` equals the inverse of `csN`.
- R3: A byte with bits [7:5]=100 or 110 is an operational command. Bit 4 is the reset level, bits [3:2] are the clock field and bits [1:0] are the supply field. All three take effect a few core cycles after the eighth rising SCLK edge.
- R4: The clock field selects the card clock as follows: 00 stops it low, 01 gives a period of 2 core cycles, 10 gives 4 and 11 gives 8.
- R5: The supply field is presented unchanged on `supplySel`: 00 off, 01 1.8 V, 10 3.0 V, 11 5.0 V.
- R6: A byte with bits [7:5]=101 is a configuration write, decoded from bits [3:0] with bit 4 ignored:
  - 0000 selects normally open;
  - 0001 selects normally closed;
  - 0010 selects special reporting;
  - 0011 selects normal reporting;
  - 0100 selects the slow slope;
  - 0101 selects the fast slope;
  - other codes change no setting.
  A configuration write never changes the clock or the supply.
- R7: Every configuration write, reserved codes included, drives `cardRst` low.
- R8: A byte with bits [7:5]=111 sets the reset level to bit 4 and leaves the clock, the supply and the configuration unchanged.
- R9: A byte whose bit 7 is 0 changes nothing.
- R10: `cardRst` is 0 whenever `supplySel` is 00, whatever reset level was written.
- R11: `ioPullDown` is 1 while `supplySel` is 00. It stays 1 for STARTUP_CYCLES core cycles after the supply leaves 00, then drops to 0.
- R12: Every high phase of `cardClk` lasts 1, 2 or 4 core cycles. A ratio change or a stop takes effect only at the end of a complete low phase.
- R13: The status byte is shifted out MSB first, starting when `csN` falls. Its layout is: [7:5]=000, [4]=detect bit, [3:2]=commanded clock field, [1:0]=supply code. It reflects the state before the byte now being received.
- R14: In normal reporting, the detect bit is 1 when a card is present. A card is present when `cardDet` is low under normally-open polarity, or high under normally-closed polarity. In special reporting, the detect bit copies the `cardDet` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (double the undivided card clock rate) |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Serial command data from the host |
| miso | output | 1 | Serial status data to the host |
| misoOe | output | 1 | MISO drive enable, high while selected |
| cardDet | input | 1 | Raw card-detect switch level |
| cardClk | output | 1 | Card clock |
| cardRst | output | 1 | Card reset level |
| supplySel | output | 2 | Card supply code |
| ioPullDown | output | 1 | Card I/O pull-down enable |
| slopeFast | output | 1 | Clock edge-rate select, 1 = fast |

## Verification
Two events can land in the same core cycle: a newly decoded clock field, and the last cycle of a running low phase of the card clock. The bench provokes this by sending ratio changes (/4 to /1, run to stop, stop to /2) while the clock is running, so the decode lands at arbitrary phases. A monitor then measures every high phase and confirms that none of them is cut short. The second pairing is the status reload at a byte boundary and the register update from that same byte. The scoreboard judges it by predicting each status byte from the state that existed before the byte was sent.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    CLK_STOP = 2'b00,
    CLK_DIV1 = 2'b01,
    CLK_DIV2 = 2'b10,
    CLK_DIV4 = 2'b11
  } clkSel_e;

  // strobes from the serial control side to the datapath
  typedef struct packed {
    logic       opWr;
    logic       cfgWr;
    logic       rstWr;
    logic [4:0] data;
  } cmdStrobe_t;

  localparam int HALF_DIV1 = 1;
  localparam int HALF_DIV2 = 2;
  localparam int HALF_DIV4 = 4;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/scc_spi_ctrl.sv
module scc_spi_ctrl
  import scc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] status,
  output logic       miso,
  output cmdStrobe_t cmd
);
  localparam int BW = $clog2(BYTE_BITS);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, mosiPipe;
  logic csS, sclkS, mosiS, csPrev, sclkPrev;
  logic sclkRise, sclkFall, csFall;
  logic [BW-1:0] bitCnt;
  logic [6:0] shiftIn;
  logic [7:0] shiftOut;
  logic [7:0] fullByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      mosiPipe <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csS      = csPipe[SYNC_STAGES-1];
  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign csFall   = ~csS & csPrev;
  assign fullByte = {shiftIn, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftIn  <= '0;
      shiftOut <= '0;
      cmd      <= '0;
    end else begin
      cmd.opWr  <= 1'b0;
      cmd.cfgWr <= 1'b0;
      cmd.rstWr <= 1'b0;
      if (csS) begin
        bitCnt <= '0;  // R2: partial byte dropped
      end else begin
        if (csFall) shiftOut <= status;
        else if (sclkFall) shiftOut <= (bitCnt == '0) ? status : {shiftOut[6:0], 1'b0};
        if (sclkRise) begin
          shiftIn <= fullByte[6:0];
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == BW'(BYTE_BITS - 1)) begin
            cmd.data  <= fullByte[4:0];
            cmd.opWr  <= fullByte[7] & ~fullByte[5];
            cmd.cfgWr <= fullByte[7] & ~fullByte[6] & fullByte[5];
            cmd.rstWr <= fullByte[7] & fullByte[6] & fullByte[5];
          end
        end
      end
    end
  end

  assign miso = shiftOut[7];
endmodule

// File: rtl/scc_clkdiv.sv
module scc_clkdiv
  import scc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  clkSel_e selReq,
  output logic    cardClk
);
  localparam int CW = $clog2(HALF_DIV4);

  clkSel_e selAct;
  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] lastIdx(clkSel_e s);
    case (s)
      CLK_DIV1: return CW'(HALF_DIV1 - 1);
      CLK_DIV2: return CW'(HALF_DIV2 - 1);
      default:  return CW'(HALF_DIV4 - 1);
    endcase
  endfunction

  // ratio changes are adopted only when a low phase completes (R12)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selAct  <= CLK_STOP;
      cnt     <= '0;
      cardClk <= 1'b0;
    end else if (cardClk) begin
      if (cnt == lastIdx(selAct)) begin
        cnt     <= '0;
        cardClk <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (selAct == CLK_STOP) begin
      selAct <= selReq;
      cnt    <= '0;
    end else if (cnt == lastIdx(selAct)) begin
      cnt     <= '0;
      selAct  <= selReq;
      cardClk <= (selReq != CLK_STOP);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scc_datapath.sv
module scc_datapath
  import scc_pkg::*;
#(
  parameter int STARTUP_CYCLES = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  cmdStrobe_t cmd,
  input  logic       cardDet,
  output logic       cardClk,
  output logic       cardRst,
  output logic [1:0] supplySel,
  output logic       ioPullDown,
  output logic       slopeFast,
  output logic [7:0] status
);
  localparam int SW = $clog2(STARTUP_CYCLES + 1);

  clkSel_e clkSelReg;
  logic [1:0] supReg;
  logic rstLvl, cfgNc, cfgSpecial, slopeReg;
  logic [SW-1:0] startCnt;
  logic [SYNC_STAGES-1:0] detPipe;
  logic detS, present, detBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSelReg  <= CLK_STOP;
      supReg     <= 2'b00;
      rstLvl     <= 1'b0;
      cfgNc      <= 1'b0;
      cfgSpecial <= 1'b0;
      slopeReg   <= 1'b0;
      startCnt   <= '0;
    end else begin
      if (cmd.opWr) begin
        rstLvl    <= cmd.data[4];
        clkSelReg <= clkSel_e'(cmd.data[3:2]);
        supReg    <= cmd.data[1:0];
      end
      if (cmd.rstWr) rstLvl <= cmd.data[4];
      if (cmd.cfgWr) begin
        rstLvl <= 1'b0;  // R7
        case (cmd.data[3:0])
          4'h0: cfgNc      <= 1'b0;
          4'h1: cfgNc      <= 1'b1;
          4'h2: cfgSpecial <= 1'b1;
          4'h3: cfgSpecial <= 1'b0;
          4'h4: slopeReg   <= 1'b0;
          4'h5: slopeReg   <= 1'b1;
          default: ;
        endcase
      end
      if (cmd.opWr && supReg == 2'b00 && cmd.data[1:0] != 2'b00)
        startCnt <= SW'(STARTUP_CYCLES);
      else if (startCnt != '0)
        startCnt <= startCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) detPipe <= '0;
    else       detPipe <= {detPipe[SYNC_STAGES-2:0], cardDet};
  end

  assign detS       = detPipe[SYNC_STAGES-1];
  assign present    = cfgNc ? detS : ~detS;
  assign detBit     = cfgSpecial ? detS : present;
  assign status     = {3'b000, detBit, clkSelReg, supReg};
  assign supplySel  = supReg;
  assign slopeFast  = slopeReg;
  assign cardRst    = rstLvl & (supReg != 2'b00);
  assign ioPullDown = (supReg == 2'b00) | (startCnt != '0);

  scc_clkdiv u_div (
    .clk    (clk),
    .rstN   (rstN),
    .selReq (clkSelReg),
    .cardClk(cardClk)
  );
endmodule

// File: rtl/scc_coupler_top.sv
module scc_coupler_top
  import scc_pkg::*;
#(
  parameter int STARTUP_CYCLES = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  output logic       misoOe,
  input  logic       cardDet,
  output logic       cardClk,
  output logic       cardRst,
  output logic [1:0] supplySel,
  output logic       ioPullDown,
  output logic       slopeFast
);
  cmdStrobe_t cmd;
  logic [7:0] status;

  assign misoOe = ~csN;

  scc_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .mosi  (mosi),
    .status(status),
    .miso  (miso),
    .cmd   (cmd)
  );

  scc_datapath #(.STARTUP_CYCLES(STARTUP_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .cardDet   (cardDet),
    .cardClk   (cardClk),
    .cardRst   (cardRst),
    .supplySel (supplySel),
    .ioPullDown(ioPullDown),
    .slopeFast (slopeFast),
    .status    (status)
  );
endmodule

// File: rtl/scc_coupler_chk.sv
module scc_coupler_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       cardClk,
  input logic       cardRst,
  input logic [1:0] supplySel,
  input logic       ioPullDown,
  input logic       slopeFast
);
  logic [3:0] highLen;
  logic [3:0] csHiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highLen <= '0;
      csHiCnt <= '0;
    end else begin
      highLen <= cardClk ? ((highLen == 4'hF) ? highLen : highLen + 1'b1) : 4'h0;
      csHiCnt <= csN ? ((csHiCnt == 4'hF) ? csHiCnt : csHiCnt + 1'b1) : 4'h0;
    end
  end

  // R12
  clk_high_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cardClk) |-> (highLen == 4'd1 || highLen == 4'd2 || highLen == 4'd4));

  // R2
  cs_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csHiCnt > 4'(SYNC_STAGES + 3)) |=> ($stable(supplySel) && $stable(slopeFast) && $stable(cardRst)));

  // R11
  startup_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(supplySel) == 2'b00 && supplySel != 2'b00) |-> ioPullDown);

  // R7
  cfg_rst_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(slopeFast) |-> !cardRst);

  // R10
  off_rst_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (supplySel == 2'b00) |-> (!cardRst && ioPullDown));
endmodule

bind scc_coupler_top scc_coupler_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .cardClk   (cardClk),
  .cardRst   (cardRst),
  .supplySel (supplySel),
  .ioPullDown(ioPullDown),
  .slopeFast (slopeFast)
);

// File: tb/tb_scc_coupler_top.sv
`timescale 1ns/1ps
module tb_scc_coupler_top;
  localparam int STARTUP = 32;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0, cardDet = 1'b0;
  logic miso, misoOe, cardClk, cardRst, ioPullDown, slopeFast;
  logic [1:0] supplySel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  logic [7:0] rxQ[$];

  // reference model state
  logic [1:0] mSup = 2'b00, mClk = 2'b00;
  logic mRst = 0, mNc = 0, mSpec = 0, mSlope = 0;

  always #2.5 clk = ~clk;

  scc_coupler_top #(.STARTUP_CYCLES(STARTUP)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .misoOe(misoOe), .cardDet(cardDet), .cardClk(cardClk), .cardRst(cardRst),
    .supplySel(supplySel), .ioPullDown(ioPullDown), .slopeFast(slopeFast)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expStatus();
    logic d;
    d = mSpec ? cardDet : (mNc ? cardDet : ~cardDet);
    return {3'b000, d, mClk, mSup};
  endfunction

  function automatic void applyModel(input logic [7:0] b);
    case (b[7:5])
      3'b100, 3'b110: begin mRst = b[4]; mClk = b[3:2]; mSup = b[1:0]; end
      3'b111: mRst = b[4];
      3'b101: begin
        mRst = 0;
        case (b[3:0])
          4'h0: mNc = 0;
          4'h1: mNc = 1;
          4'h2: mSpec = 1;
          4'h3: mSpec = 0;
          4'h4: mSlope = 0;
          4'h5: mSlope = 1;
          default: ;
        endcase
      end
      default: ;
    endcase
  endfunction

  // driver: pushes the predicted status, then shifts the byte
  task automatic spiByte(input logic [7:0] b);
    logic [7:0] rx;
    expQ.push_back(expStatus());
    csN = 0;
    tick(8);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      tick(4);
      rx[i] = miso;
      sclk = 1;
      tick(4);
      sclk = 0;
    end
    tick(4);
    csN = 1;
    tick(6);
    rxQ.push_back(rx);
    applyModel(b);
  endtask

  task automatic spiPartial(input int n);
    csN = 0;
    tick(8);
    for (int i = 0; i < n; i++) begin
      mosi = 1; tick(4); sclk = 1; tick(4); sclk = 0;
    end
    tick(4);
    csN = 1;
    tick(6);
  endtask

  task automatic checkOuts(input string tag);
    chk(supplySel == mSup, {tag, " supply"}, supplySel, mSup);
    chk(cardRst == (mRst && mSup != 2'b00), {tag, " reset"}, cardRst, mRst && mSup != 2'b00);
    chk(slopeFast == mSlope, {tag, " slope"}, slopeFast, mSlope);
  endtask

  task automatic period(output int p);
    int w = 0;
    p = 0;
    while (cardClk !== 1'b0 && w < 100) begin tick(1); w++; end
    while (cardClk !== 1'b1 && w < 100) begin tick(1); w++; end
    while (cardClk !== 1'b0 && p < 100) begin tick(1); p++; end
    while (cardClk !== 1'b1 && p < 100) begin tick(1); p++; end
  endtask

  // monitor: scoreboard for status bytes
  initial begin
    forever begin
      @(negedge clk);
      while (rxQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] got, want;
        got = rxQ.pop_front();
        want = expQ.pop_front();
        chk(got == want, "R13 R14 status byte", got, want);
      end
    end
  end

  // monitor: high-phase length of the card clock (R12)
  initial begin
    int run = 0;
    logic prev = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (cardClk) run++;
        else if (prev) begin
          chk(run == 1 || run == 2 || run == 4, "R12 high phase", run, 4);
          run = 0;
        end
        prev = cardClk;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p;
    int ones;
    tick(5);
    // R1
    chk(supplySel == 2'b00, "R1 supply", supplySel, 0);
    chk(cardClk == 1'b0, "R1 clock", cardClk, 0);
    chk(cardRst == 1'b0, "R1 reset", cardRst, 0);
    chk(ioPullDown == 1'b1, "R1 pulldown", ioPullDown, 1);
    chk(slopeFast == 1'b0, "R1 slope", slopeFast, 0);
    chk(misoOe == 1'b0, "R2 oe idle", misoOe, 0);
    rstN = 1;
    tick(5);
    csN = 0; tick(1);
    chk(misoOe == 1'b1, "R2 oe selected", misoOe, 1);
    csN = 1; tick(6);

    spiByte(8'h96);                       // R3 R5: op, reset 1, /1, 3.0 V
    checkOuts("R3");
    chk(ioPullDown == 1'b1, "R11 startup window", ioPullDown, 1);
    period(p); chk(p == 2, "R4 div1 period", p, 2);
    tick(40);
    chk(ioPullDown == 1'b0, "R11 after startup", ioPullDown, 0);

    spiByte(8'h9B);                       // R4 /2, R5 5.0 V
    checkOuts("R5");
    period(p); chk(p == 4, "R4 div2 period", p, 4);

    spiByte(8'hDD);                       // second address, /4, 1.8 V
    checkOuts("R3 second address");
    period(p); chk(p == 8, "R4 div4 period", p, 8);

    spiByte(8'h95);                       // R12: /4 to /1 while running
    period(p); chk(p == 2, "R12 switch to div1", p, 2);

    spiByte(8'h91);                       // R4 stop
    tick(20);
    ones = 0;
    for (int i = 0; i < 40; i++) begin tick(1); if (cardClk) ones++; end
    chk(ones == 0, "R4 clock stopped low", ones, 0);

    spiByte(8'hA5);                       // R6 fast slope, R7 reset low
    checkOuts("R6 R7");
    chk(cardRst == 1'b0, "R7 cfg reset low", cardRst, 0);

    spiByte(8'hE0);                       // R8 reset-only low
    checkOuts("R8 low");
    spiByte(8'hF0);                       // R8 reset-only high
    checkOuts("R8 high");
    chk(cardRst == 1'b1, "R8 reset follows bit4", cardRst, 1);

    spiByte(8'h7F);                       // R9 foreign address
    checkOuts("R9");
    chk(cardClk == 1'b0, "R9 clock still stopped", cardClk, 0);

    // R2: SCLK activity with csN high
    for (int i = 0; i < 8; i++) begin
      mosi = i[0]; tick(4); sclk = 1; tick(4); sclk = 0;
    end
    tick(6);
    checkOuts("R2 deselected");
    chk(misoOe == 1'b0, "R2 oe deselected", misoOe, 0);
    spiPartial(5);
    spiByte(8'h99);                       // R2: partial byte dropped
    checkOuts("R2 after partial");
    period(p); chk(p == 4, "R2 R12 restart div2", p, 4);

    spiByte(8'hA2);                       // R14 special mode
    spiByte(8'hA1);                       // normally closed
    spiByte(8'hA3);                       // normal mode
    cardDet = 1; tick(4);
    spiByte(8'hA7);                       // R6 reserved code
    checkOuts("R6 reserved");
    spiByte(8'hB4);                       // R6 bit4 ignored, slow slope
    checkOuts("R6 bit4 ignored");
    chk(slopeFast == 1'b0, "R6 slow slope", slopeFast, 0);

    spiByte(8'h9C);                       // R10 supply off with reset level 1
    checkOuts("R10");
    chk(cardRst == 1'b0, "R10 reset low when off", cardRst, 0);
    chk(ioPullDown == 1'b1, "R11 pulldown when off", ioPullDown, 1);

    spiByte(8'h80);
    tick(10);
    chk(expQ.size() == 0, "R13 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule